// File: doc/BRIEF.md
# Flash Block-Lock Command Controller

This block is the command front end that guards a parallel NOR flash array against unwanted writes, one protection bit per erase block. Bus write cycles carry command bytes. A two-cycle sequence (a lock setup byte, then a confirm byte) either protects the single block addressed by the confirm cycle, or removes protection from every block at once. Further single-cycle commands select what a read returns (array data, the status byte, or per-block lock information) and clear the sticky error flags.

While a lock change is in progress, the block drops its ready output and the status byte shows busy. A request is refused when the array reports a running or suspended program/erase, or when the protection supply is flagged low. A refused request leaves the lock bits as they were and raises the error flag that matches the request. Program and erase requests from the array sequencer are granted or rejected against the current lock bits. The lock bits have their own power-on reset and keep their values through the ordinary device reset.

Top module: `flash_lock_ctrl`

## Requirements
- R1: A setup write of 60h followed by a confirm write of 01h to any address inside block b sets the lock bit of block b alone. The block index is the address bits above the in-block offset.
- R2: A setup write of 60h followed by a confirm write of D0h to any address clears every lock bit in the same cycle.
- R3: When pe_req is high, pe_reject equals the lock bit of the block addressed by pe_addr, and pe_grant is its inverse. Both are low when pe_req is low.
- R4: Read routing selects array_rdata after FFh or after reset, and the status byte after 70h or 60h, or after any confirm byte. After 90h, a read at offset 2 of a block returns 0000000L, where L=1 means locked, and other offsets return 00h.
- R5: After a valid confirm write, ready is low for exactly LOCK_CYCLES clock cycles, and the lock change lands in the cycle ready returns high. Status bit 7 always equals ready.
- R6: A confirm that arrives while array_busy or array_susp is high changes no lock bit. It sets status bit 4 for a set request or status bit 5 for a clear request.
- R7: A confirm that arrives while prot_supply_ok is low likewise changes no lock bit, and it sets the same error bits as in R6.
- R8: A confirm byte other than 01h or D0h sets both status bits 4 and 5, returns to idle without a busy period, and changes no lock bit.
- R9: Status bits 4 and 5 stay set until a write of 50h while idle. All other status bits read as 0.
- R10: rst_n returns the command state, the read routing and the error flags to their idle values, but keeps the lock bits. por_n clears all lock bits.
- R11: Bus writes while ready is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low, asynchronous assert |
| por_n | input | 1 | Power-on reset of the lock bits, active low |
| bus_we | input | 1 | Bus write cycle strobe, one per clock |
| bus_addr | input | ADDR_W | Bus address: {block index, in-block offset} |
| bus_wdata | input | 8 | Command byte |
| bus_rdata | output | 8 | Read data selected by the read routing |
| array_rdata | input | 8 | Data from the cell array |
| prot_supply_ok | input | 1 | Protection supply above its lockout level |
| array_busy | input | 1 | Program or erase running |
| array_susp | input | 1 | Program or erase suspended |
| pe_req | input | 1 | Program/erase request from the array sequencer |
| pe_addr | input | ADDR_W | Address of the program/erase request |
| pe_grant | output | 1 | Request allowed |
| pe_reject | output | 1 | Request refused by a lock bit |
| ready | output | 1 | High when no lock operation is in progress |

## Verification
The bench builds the block with 8 blocks, a 3-bit in-block offset and LOCK_CYCLES set to 5 instead of the default 4. The narrow offset keeps the block-base-plus-2 reads and the non-base confirm addresses easy to write. The non-default busy length exposes a counter that ignores its parameter. With eight blocks, the bench can lock two separate blocks, clear them together, and read every block back through the information mode. Each refusal cause and the bad-confirm path are exercised separately, with the sticky flags checked before and after clearing.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_SETUP = 2'd1,
    CS_BUSY  = 2'd2
  } cmd_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_INFO   = 2'd2
  } rd_mode_e;

  localparam logic [7:0] OP_LOCK_SETUP = 8'h60;
  localparam logic [7:0] OP_SET_CONF   = 8'h01;
  localparam logic [7:0] OP_CLR_CONF   = 8'hD0;
  localparam logic [7:0] OP_CLR_SR     = 8'h50;
  localparam logic [7:0] OP_READ_INFO  = 8'h90;
  localparam logic [7:0] OP_READ_SR    = 8'h70;
  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;

endpackage

// File: rtl/lock_cmd_fsm.sv
module lock_cmd_fsm
  import flash_lock_pkg::*;
#(
  parameter int BLK_W       = 3,
  parameter int LOCK_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic             refuse,
  output logic             ready,
  output rd_mode_e         rd_mode,
  output logic             err_set_lk,
  output logic             err_clr_lk,
  output logic             upd_set,
  output logic             upd_clr_all,
  output logic [BLK_W-1:0] upd_blk
);

  localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES - 1);

  cmd_state_e       state_q, state_d;
  rd_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             e4_q, e4_d, e5_q, e5_d;
  logic             op_clr_q, op_clr_d, op_fail_q, op_fail_d;
  logic [BLK_W-1:0] op_blk_q, op_blk_d;
  logic             cap_en;
  logic             done;

  assign done = (state_q == CS_BUSY) && (cnt_q == '0);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    cnt_d     = cnt_q;
    e4_d      = e4_q;
    e5_d      = e5_q;
    cap_en    = 1'b0;
    op_clr_d  = (wr_data == OP_CLR_CONF);
    op_fail_d = refuse;
    op_blk_d  = wr_blk;
    unique case (state_q)
      CS_IDLE: begin
        if (wr_en) begin
          unique case (wr_data)
            OP_LOCK_SETUP: begin
              state_d = CS_SETUP;
              mode_d  = RM_STATUS;
            end
            OP_CLR_SR: begin
              e4_d = 1'b0;
              e5_d = 1'b0;
            end
            OP_READ_INFO:  mode_d = RM_INFO;
            OP_READ_SR:    mode_d = RM_STATUS;
            OP_READ_ARRAY: mode_d = RM_ARRAY;
            default: ;
          endcase
        end
      end
      CS_SETUP: begin
        if (wr_en) begin
          mode_d = RM_STATUS;
          if ((wr_data == OP_SET_CONF) || (wr_data == OP_CLR_CONF)) begin
            state_d = CS_BUSY;
            cnt_d   = CNT_LOAD;
            cap_en  = 1'b1;
          end else begin
            state_d = CS_IDLE;
            e4_d    = 1'b1;
            e5_d    = 1'b1;
          end
        end
      end
      CS_BUSY: begin
        if (cnt_q == '0) begin
          state_d = CS_IDLE;
          if (op_fail_q) begin
            if (op_clr_q) e5_d = 1'b1;
            else          e4_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      mode_q  <= RM_ARRAY;
      cnt_q   <= '0;
      e4_q    <= 1'b0;
      e5_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      e4_q    <= e4_d;
      e5_q    <= e5_d;
    end
  end

  // captured operation, loaded on a valid confirm only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_clr_q  <= 1'b0;
      op_fail_q <= 1'b0;
      op_blk_q  <= '0;
    end else if (cap_en) begin
      op_clr_q  <= op_clr_d;
      op_fail_q <= op_fail_d;
      op_blk_q  <= op_blk_d;
    end
  end

  assign ready       = (state_q != CS_BUSY);
  assign rd_mode     = mode_q;
  assign err_set_lk  = e4_q;
  assign err_clr_lk  = e5_q;
  assign upd_set     = done && !op_fail_q && !op_clr_q;
  assign upd_clr_all = done && !op_fail_q && op_clr_q;
  assign upd_blk     = op_blk_q;

endmodule

// File: rtl/lock_bit_file.sv
module lock_bit_file #(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  set_en,
  input  logic [BLK_W-1:0]      set_blk,
  input  logic                  clr_all,
  output logic [NUM_BLOCKS-1:0] lock_vec
);

  for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_bit
    logic en_b;
    assign en_b = clr_all || (set_en && (set_blk == BLK_W'(gi)));
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     lock_vec[gi] <= 1'b0;
      else if (en_b)  lock_vec[gi] <= !clr_all;
    end
  end

endmodule

// File: rtl/lock_read_mux.sv
module lock_read_mux
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3,
  parameter int OFS_W      = 4
) (
  input  rd_mode_e              rd_mode,
  input  logic [BLK_W-1:0]      rd_blk,
  input  logic [OFS_W-1:0]      rd_ofs,
  input  logic [7:0]            status,
  input  logic [7:0]            array_data,
  input  logic [NUM_BLOCKS-1:0] lock_vec,
  output logic [7:0]            rdata
);

  logic lock_bit;

  always_comb begin
    lock_bit = 1'b0;
    if (32'(rd_blk) < NUM_BLOCKS) lock_bit = lock_vec[rd_blk];
  end

  always_comb begin
    unique case (rd_mode)
      RM_STATUS: rdata = status;
      RM_INFO:   rdata = (rd_ofs == OFS_W'(2)) ? {7'b0, lock_bit} : 8'h00;
      default:   rdata = array_data;
    endcase
  end

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLK_OFS_W   = 4,
  parameter int LOCK_CYCLES = 4,
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int ADDR_W = BLK_W + BLK_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        array_rdata,
  input  logic              prot_supply_ok,
  input  logic              array_busy,
  input  logic              array_susp,
  input  logic              pe_req,
  input  logic [ADDR_W-1:0] pe_addr,
  output logic              pe_grant,
  output logic              pe_reject,
  output logic              ready
);

  rd_mode_e              rd_mode;
  logic                  err_set_lk, err_clr_lk;
  logic                  upd_set, upd_clr_all;
  logic [BLK_W-1:0]      upd_blk;
  logic [NUM_BLOCKS-1:0] lock_vec;
  logic [7:0]            status;
  logic [BLK_W-1:0]      bus_blk, pe_blk;
  logic                  refuse;
  logic                  pe_locked;

  assign bus_blk = bus_addr[ADDR_W-1:BLK_OFS_W];
  assign pe_blk  = pe_addr[ADDR_W-1:BLK_OFS_W];
  assign refuse  = array_busy || array_susp || !prot_supply_ok;

  lock_cmd_fsm #(.BLK_W(BLK_W), .LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_data(bus_wdata),
    .wr_blk(bus_blk), .refuse(refuse), .ready(ready), .rd_mode(rd_mode),
    .err_set_lk(err_set_lk), .err_clr_lk(err_clr_lk), .upd_set(upd_set),
    .upd_clr_all(upd_clr_all), .upd_blk(upd_blk)
  );

  lock_bit_file #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_bits (
    .clk(clk), .por_n(por_n), .set_en(upd_set), .set_blk(upd_blk),
    .clr_all(upd_clr_all), .lock_vec(lock_vec)
  );

  assign status = {ready, 1'b0, err_clr_lk, err_set_lk, 4'b0000};

  lock_read_mux #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .OFS_W(BLK_OFS_W)) u_rmux (
    .rd_mode(rd_mode), .rd_blk(bus_blk), .rd_ofs(bus_addr[BLK_OFS_W-1:0]),
    .status(status), .array_data(array_rdata), .lock_vec(lock_vec),
    .rdata(bus_rdata)
  );

  always_comb begin
    pe_locked = 1'b0;
    if (32'(pe_blk) < NUM_BLOCKS) pe_locked = lock_vec[pe_blk];
  end

  assign pe_grant  = pe_req && !pe_locked;
  assign pe_reject = pe_req && pe_locked;

endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk #(
  parameter int NUM_BLOCKS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  por_n,
  input logic                  bus_we,
  input logic                  ready,
  input logic                  pe_req,
  input logic                  pe_grant,
  input logic                  pe_reject,
  input logic [NUM_BLOCKS-1:0] lock_vec
);

  // R3: a request is answered by exactly one of grant or reject
  p_pe_answer_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    pe_req == (pe_grant ^ pe_reject));

  // R1: a set operation adds at most one locked block per cycle
  p_one_block_set_r1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $countones(lock_vec & ~$past(lock_vec)) <= 1);

  // R2: whenever any lock bit falls, all of them end up clear
  p_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (|($past(lock_vec) & ~lock_vec)) |-> (lock_vec == '0));

  // R5: lock bits change only in the cycle ready returns high
  p_change_on_ready_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !$stable(lock_vec) |-> $rose(ready));

  // R11: ready falls only after a bus write
  p_busy_from_write_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $fell(ready) |-> $past(bus_we));

endmodule

bind flash_lock_ctrl flash_lock_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_we(bus_we), .ready(ready),
  .pe_req(pe_req), .pe_grant(pe_grant), .pe_reject(pe_reject),
  .lock_vec(lock_vec)
);

// File: tb/tb_flash_lock_ctrl.sv
`timescale 1ns/1ps
module tb_flash_lock_ctrl;

  localparam int NB  = 8;
  localparam int OFS = 3;
  localparam int LC  = 5;
  localparam int AW  = 3 + OFS;

  logic          clk = 1'b0;
  logic          rst_n, por_n, bus_we;
  logic [AW-1:0] bus_addr, pe_addr;
  logic [7:0]    bus_wdata, bus_rdata, array_rdata;
  logic          prot_supply_ok, array_busy, array_susp;
  logic          pe_req, pe_grant, pe_reject, ready;

  always #2.5 clk = ~clk;

  flash_lock_ctrl #(.NUM_BLOCKS(NB), .BLK_OFS_W(OFS), .LOCK_CYCLES(LC)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .array_rdata(array_rdata), .prot_supply_ok(prot_supply_ok),
    .array_busy(array_busy), .array_susp(array_susp), .pe_req(pe_req),
    .pe_addr(pe_addr), .pe_grant(pe_grant), .pe_reject(pe_reject),
    .ready(ready)
  );

  // scoreboard: sel 0 = bus_rdata, 1 = ready, 2 = {grant, reject}
  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t   sbq[$];
  int      n_chk = 0;
  int      n_fail = 0;
  logic    model_lock [NB];
  bit      finished = 1'b0;

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      case (it.sel)
        0:       act = bus_rdata;
        1:       act = {7'b0, ready};
        default: act = {6'b0, pe_grant, pe_reject};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [AW-1:0] mk(input int blk, input int ofs);
    return {3'(blk), 3'(ofs)};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic chk(input int sel, input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    bus_addr = a;
    sbq.push_back('{sel: sel, exp: e, tag: tag});
    @(negedge clk); #1;
  endtask

  task automatic lock_op(input logic [AW-1:0] a, input logic [7:0] conf);
    wr(a, 8'h60);
    wr(a, conf);
    tick(LC);
  endtask

  task automatic chk_locks(input string tag);
    wr('0, 8'h90);
    for (int b = 0; b < NB; b++)
      chk(0, mk(b, 2), {7'b0, model_lock[b]}, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) model_lock[b] = 1'b0;
    rst_n = 0; por_n = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    array_rdata = 8'hA5; prot_supply_ok = 1; array_busy = 0; array_susp = 0;
    pe_req = 0; pe_addr = '0;
    tick(3);
    por_n = 1; rst_n = 1;
    tick(1);

    // reset state
    chk(1, '0, 8'h01, "R5 ready after reset");
    chk(0, mk(1, 1), 8'hA5, "R4 array read after reset");
    chk(2, '0, 8'h00, "R3 no request idle");
    wr('0, 8'h70);
    chk(0, '0, 8'h80, "R9 status clean after reset");

    // set lock on block 3 via a non-base address, with busy timing
    wr('0, 8'hFF);
    wr(mk(3, 5), 8'h60);
    chk(0, mk(2, 0), 8'h80, "R4 status after setup");
    wr(mk(3, 5), 8'h01);
    chk(1, '0, 8'h00, "R5 busy after confirm");
    chk(0, '0, 8'h00, "R5 status bit7 low while busy");
    tick(LC - 2);
    chk(1, '0, 8'h00, "R5 still busy last cycle");
    tick(1);
    chk(1, '0, 8'h01, "R5 ready after LOCK_CYCLES");
    model_lock[3] = 1'b1;
    chk_locks("R1 only block 3 locked");
    chk(0, mk(3, 1), 8'h00, "R4 info other offset");

    // program/erase gating
    pe_req = 1; pe_addr = mk(3, 7);
    chk(2, '0, 8'h01, "R3 locked block rejected");
    pe_addr = mk(2, 7);
    chk(2, '0, 8'h02, "R3 unlocked block granted");
    pe_req = 0;

    // second lock, then clear-all from another block
    lock_op(mk(6, 0), 8'h01);
    model_lock[6] = 1'b1;
    chk_locks("R1 block 6 added");
    lock_op(mk(0, 4), 8'hD0);
    for (int b = 0; b < NB; b++) model_lock[b] = 1'b0;
    chk(0, '0, 8'h80, "R2 clear-all status clean");
    chk_locks("R2 all unlocked");

    // refusal while array busy
    array_busy = 1;
    lock_op(mk(1, 0), 8'h01);
    array_busy = 0;
    chk(0, '0, 8'h90, "R6 set refused busy sets bit4");
    wr('0, 8'h70);
    chk(0, '0, 8'h90, "R9 bit4 sticky");
    chk_locks("R6 block 1 stays unlocked");
    wr('0, 8'h50);
    wr('0, 8'h70);
    chk(0, '0, 8'h80, "R9 cleared by 50h");

    // refusal while suspended, clear request
    lock_op(mk(2, 0), 8'h01);
    model_lock[2] = 1'b1;
    array_susp = 1;
    lock_op(mk(5, 0), 8'hD0);
    array_susp = 0;
    chk(0, '0, 8'hA0, "R6 clear refused susp sets bit5");
    chk_locks("R6 block 2 kept");
    wr('0, 8'h50);

    // protection supply low
    prot_supply_ok = 0;
    lock_op(mk(4, 1), 8'h01);
    chk(0, '0, 8'h90, "R7 set refused supply low");
    wr('0, 8'h50);
    lock_op(mk(4, 1), 8'hD0);
    prot_supply_ok = 1;
    chk(0, '0, 8'hA0, "R7 clear refused supply low");
    chk_locks("R7 locks unchanged");
    wr('0, 8'h50);

    // bad confirm
    wr(mk(4, 0), 8'h60);
    wr(mk(4, 0), 8'h33);
    chk(1, '0, 8'h01, "R8 no busy on bad confirm");
    chk(0, '0, 8'hB0, "R8 both error bits");
    chk_locks("R8 no lock change");
    wr('0, 8'h50);
    wr('0, 8'h70);
    chk(0, '0, 8'h80, "R9 both cleared");

    // writes during busy ignored
    wr(mk(4, 0), 8'h60);
    wr(mk(4, 0), 8'h01);
    wr(mk(5, 0), 8'hFF);
    tick(LC);
    chk(0, '0, 8'h80, "R11 read mode kept through busy write");
    model_lock[4] = 1'b1;
    chk_locks("R11 block 4 locked");

    // device reset keeps locks, power-on clears
    wr(mk(0, 0), 8'h60);
    wr(mk(0, 0), 8'h22);
    rst_n = 0; tick(2); rst_n = 1; tick(1);
    chk(0, '0, 8'hA5, "R10 read array after reset");
    wr('0, 8'h70);
    chk(0, '0, 8'h80, "R10 errors cleared by reset");
    chk_locks("R10 locks survive reset");
    por_n = 0; tick(2); por_n = 1; tick(1);
    for (int b = 0; b < NB; b++) model_lock[b] = 1'b0;
    chk_locks("R10 power-on clears locks");

    tick(2);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule